// File: doc/BRIEF.md
# Read Strobe Delay Window Calibrator

This block is a hardware sequencer that finds a read strobe delay for a memory interface with several byte lanes (two by default). Each lane's delay is a coarse field and a fine field, both four bits wide by default. For every lane in turn, the engine first climbs the delay to find the largest setting that still passes, then descends to find the smallest one. Once all lanes are done, it writes a setting centred between the two edges into a packed delay word.

The memory pattern test lives outside the block. The engine drives a candidate delay word, pulses a request together with a pattern bias code, and waits for a done pulse that carries a pass flag. The packed delay word is the block's only view of the delay line. Between probes it is parked at a neutral value. While one lane is being probed, every other lane sees that neutral byte. The lower edge search is floored by bounds derived from the DLL reading captured at start.

Top module: `dqs_cal_engine`

## Requirements
- R1: After a synchronous reset the delay word, `busy_o`, `done_o`, `test_req_o` and all result outputs are zero. The request is a single-cycle pulse and is never raised while idle.
- R2: Byte i of the delay word belongs to lane i, with coarse in its upper nibble and fine in its lower nibble. During a probe, every lane other than the one under test holds 0x74. The whole word returns to 0x7474 in the cycle after each test done.
- R3: Upper coarse search: coarse starts at 7 with fine at 0xF and rises while the probe passes. The first failing coarse value is recorded as the coarse maximum. If 15 still passes, 16 is recorded. Any coarse value above 15 is driven as 15.
- R4: Upper fine search: coarse is held at the coarse maximum and fine rises from 0 while passing. The fine maximum is the last passing fine value (15 if all pass). If fine 0 already fails, the coarse maximum drops by one and the fine maximum is 0xF.
- R5: The coarse and fine lower bounds are each 8 minus the matching 4-bit DLL reading when that reading is at most 8, and 0 otherwise. The readings are captured when a run starts.
- R6: Lower coarse search: coarse starts at 6 with fine at 0 and falls while passing. The search stops at a failing value (recorded as the coarse minimum), or at a passing value equal to the bound (recorded). If the next value would fall below the bound, that next value is recorded.
- R7: Lower fine search: coarse is held at the coarse minimum and fine falls from 0xF. On a failure the recorded fine minimum is one above the failing value. If that gives 0x10, the coarse minimum rises by one and the fine minimum is 0. A passing value equal to the fine bound is recorded as it stands.
- R8: Lanes are calibrated in ascending order, each through the upper coarse, upper fine, lower coarse and lower fine searches in that order.
- R9: Each lane's centre coarse is (max_c + min_c) >> 1. Let t = 4·((max_c + min_c) mod 2) + ((max_f + min_f) >> 1). If t ≥ 16, the coarse rises by one and the fine is t − 8; otherwise the fine is t. The final word packs the centres per R2 (coarse truncated to 4 bits).
- R10: Probes in the upper searches carry bias code 3. Probes in the lower searches carry bias code 1.
- R11: The final word appears in the same cycle as a one-cycle `done_o` pulse, with `busy_o` low. From then on the min/max outputs hold the per-lane edges.
- R12: A start pulse while busy is ignored: the run in progress, its probe sequence and its result are unchanged, even if the DLL inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a calibration run (sampled only when idle) |
| dll_coarse_i | input | 4 | DLL coarse reading, captured at start |
| dll_fine_i | input | 4 | DLL fine reading, captured at start |
| test_req_o | output | 1 | One-cycle probe request |
| test_bias_o | output | 2 | Pattern bias code for the probe |
| test_done_i | input | 1 | Probe finished (one-cycle pulse) |
| test_pass_i | input | 1 | Probe result, valid with test_done_i |
| dly_word_o | output | 16 | Packed delay word driven to the delay line |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| max_c_o | output | 10 | Coarse maximum per lane, 5 bits each, lane 0 low |
| max_f_o | output | 8 | Fine maximum per lane, 4 bits each |
| min_c_o | output | 10 | Coarse minimum per lane, 5 bits each |
| min_f_o | output | 8 | Fine minimum per lane, 4 bits each |

## Verification
A probe's delay word and request become visible one clock after the engine enters its issue step. The word goes back to 0x7474 one clock after the edge that samples a test done. The final word and `done_o` arrive two clocks after the last test done is sampled. The bench samples every output on the falling edge. It records each request, with its word and bias, in the half-cycle where the request is high, and checks the parked word on the falling edge that follows the one on which the done pulse was seen. The result checks wait for the falling edge where `done_o` is high, and the following falling edge confirms the pulse lasted one cycle. A reference model built from the requirements predicts the full probe sequence and every edge from the stub's pass window.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;

  typedef enum logic [1:0] {
    PH_UP_C,
    PH_UP_F,
    PH_LO_C,
    PH_LO_F
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL,
    ST_CENTRE
  } state_e;

endpackage

// File: rtl/dqs_bound_calc.sv
module dqs_bound_calc #(
  parameter int FW  = 4,
  parameter int REF = 8
) (
  input  logic [FW-1:0] dll_i,
  output logic [FW:0]   bound_o
);
  localparam logic [FW:0] REF_V = (FW+1)'(REF);

  always_comb begin
    if ({1'b0, dll_i} <= REF_V) bound_o = REF_V - {1'b0, dll_i};
    else                        bound_o = '0;
  end
endmodule

// File: rtl/dqs_lane_centre.sv
module dqs_lane_centre #(
  parameter int FW        = 4,
  parameter int HALF_STEP = 4,
  parameter int REBASE    = 8
) (
  input  logic [FW:0]   max_c_i,
  input  logic [FW:0]   min_c_i,
  input  logic [FW-1:0] max_f_i,
  input  logic [FW-1:0] min_f_i,
  output logic [FW-1:0] cen_c_o,
  output logic [FW-1:0] cen_f_o
);
  localparam int SW = FW + 2;
  localparam logic [SW-1:0] WRAP = SW'(1 << FW);

  logic [SW-1:0] c_sum;
  logic [SW-1:0] f_half;
  logic [SW-1:0] t_val;
  logic [SW-1:0] c_half;

  always_comb begin
    c_sum  = {1'b0, max_c_i} + {1'b0, min_c_i};
    f_half = (SW'(max_f_i) + SW'(min_f_i)) >> 1;
    c_half = c_sum >> 1;
    t_val  = (c_sum[0] ? SW'(HALF_STEP) : '0) + f_half;
    if (t_val >= WRAP) begin
      cen_c_o = FW'(c_half + 1'b1);
      cen_f_o = FW'(t_val - WRAP + SW'(REBASE));
    end else begin
      cen_c_o = FW'(c_half);
      cen_f_o = FW'(t_val);
    end
  end
endmodule

// File: rtl/dqs_probe_word.sv
module dqs_probe_word #(
  parameter int FW        = 4,
  parameter int NL        = 2,
  parameter int PARK_BYTE = 8'h74,
  parameter int LIW       = 1
) (
  input  logic [LIW-1:0]     lane_i,
  input  logic [FW:0]        coarse_i,
  input  logic [FW-1:0]      fine_i,
  output logic [NL*2*FW-1:0] word_o
);
  localparam int LW = 2 * FW;
  localparam logic [LW-1:0] PARK_V = LW'(PARK_BYTE);

  logic [FW-1:0] c_sat;
  assign c_sat = coarse_i[FW] ? {FW{1'b1}} : coarse_i[FW-1:0];

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign word_o[i*LW +: LW] = (lane_i == LIW'(i)) ? {c_sat, fine_i} : PARK_V;
  end
endmodule

// File: rtl/dqs_cal_engine.sv
module dqs_cal_engine
  import dqs_cal_pkg::*;
#(
  parameter int FW          = 4,
  parameter int NL          = 2,
  parameter int UP_C_START  = 7,
  parameter int LO_C_START  = 6,
  parameter int BOUND_REF   = 8,
  parameter int PARK_BYTE   = 8'h74,
  parameter int BW          = 2,
  parameter int BIAS_UP     = 3,
  parameter int BIAS_LO     = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [FW-1:0]        dll_coarse_i,
  input  logic [FW-1:0]        dll_fine_i,
  output logic                 test_req_o,
  output logic [BW-1:0]        test_bias_o,
  input  logic                 test_done_i,
  input  logic                 test_pass_i,
  output logic [NL*2*FW-1:0]   dly_word_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [NL*(FW+1)-1:0] max_c_o,
  output logic [NL*FW-1:0]     max_f_o,
  output logic [NL*(FW+1)-1:0] min_c_o,
  output logic [NL*FW-1:0]     min_f_o
);
  localparam int CW  = FW + 1;
  localparam int LW  = 2 * FW;
  localparam int RW  = NL * LW;
  localparam int LIW = (NL > 1) ? $clog2(NL) : 1;
  localparam logic [CW-1:0]  C_FMAX    = CW'((1 << FW) - 1);
  localparam logic [CW-1:0]  C_UPST    = CW'(UP_C_START);
  localparam logic [CW-1:0]  C_LOST    = CW'(LO_C_START);
  localparam logic [FW-1:0]  F_MAX     = {FW{1'b1}};
  localparam logic [LIW-1:0] LAST_LANE = LIW'(NL - 1);
  localparam logic [RW-1:0]  PARK_WORD = {NL{LW'(PARK_BYTE)}};

  state_e   state_q;
  phase_e   phase_q;
  logic [LIW-1:0] lane_q;
  logic [CW-1:0]  t_q;
  logic           pass_q;
  logic [FW-1:0]  dllc_q, dllf_q;
  logic [CW-1:0]  bnd_c, bnd_f;

  logic [CW-1:0]  maxc_q [NL];
  logic [FW-1:0]  maxf_q [NL];
  logic [CW-1:0]  minc_q [NL];
  logic [FW-1:0]  minf_q [NL];

  logic [CW-1:0]  csel;
  logic [FW-1:0]  fsel;
  logic [RW-1:0]  probe_word;
  logic [RW-1:0]  final_word;

  dqs_bound_calc #(.FW(FW), .REF(BOUND_REF)) u_bnd_c (.dll_i(dllc_q), .bound_o(bnd_c));
  dqs_bound_calc #(.FW(FW), .REF(BOUND_REF)) u_bnd_f (.dll_i(dllf_q), .bound_o(bnd_f));

  always_comb begin
    case (phase_q)
      PH_UP_C: begin csel = t_q;            fsel = F_MAX;         end
      PH_UP_F: begin csel = maxc_q[lane_q]; fsel = t_q[FW-1:0];   end
      PH_LO_C: begin csel = t_q;            fsel = '0;            end
      default: begin csel = minc_q[lane_q]; fsel = t_q[FW-1:0];   end
    endcase
  end

  dqs_probe_word #(.FW(FW), .NL(NL), .PARK_BYTE(PARK_BYTE), .LIW(LIW)) u_probe (
    .lane_i  (lane_q),
    .coarse_i(csel),
    .fine_i  (fsel),
    .word_o  (probe_word)
  );

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [FW-1:0] cc, cf;
    dqs_lane_centre #(.FW(FW)) u_centre (
      .max_c_i(maxc_q[i]),
      .min_c_i(minc_q[i]),
      .max_f_i(maxf_q[i]),
      .min_f_i(minf_q[i]),
      .cen_c_o(cc),
      .cen_f_o(cf)
    );
    assign final_word[i*LW +: LW] = {cc, cf};
    assign max_c_o[i*CW +: CW]    = maxc_q[i];
    assign min_c_o[i*CW +: CW]    = minc_q[i];
    assign max_f_o[i*FW +: FW]    = maxf_q[i];
    assign min_f_o[i*FW +: FW]    = minf_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_UP_C;
      lane_q      <= '0;
      t_q         <= '0;
      pass_q      <= 1'b0;
      dllc_q      <= '0;
      dllf_q      <= '0;
      dly_word_o  <= '0;
      test_req_o  <= 1'b0;
      test_bias_o <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      for (int i = 0; i < NL; i++) begin
        maxc_q[i] <= '0;
        maxf_q[i] <= '0;
        minc_q[i] <= '0;
        minf_q[i] <= '0;
      end
    end else begin
      done_o     <= 1'b0;
      test_req_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            busy_o     <= 1'b1;
            lane_q     <= '0;
            phase_q    <= PH_UP_C;
            t_q        <= C_UPST;
            dllc_q     <= dll_coarse_i;
            dllf_q     <= dll_fine_i;
            dly_word_o <= PARK_WORD;
            state_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          dly_word_o  <= probe_word;
          test_req_o  <= 1'b1;
          test_bias_o <= (phase_q == PH_UP_C || phase_q == PH_UP_F) ?
                         BW'(BIAS_UP) : BW'(BIAS_LO);
          state_q     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (test_done_i) begin
            pass_q     <= test_pass_i;
            dly_word_o <= PARK_WORD;
            state_q    <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          state_q <= ST_ISSUE;
          case (phase_q)
            PH_UP_C: begin
              if (!pass_q || t_q == C_FMAX) begin
                maxc_q[lane_q] <= pass_q ? t_q + 1'b1 : t_q;
                phase_q        <= PH_UP_F;
                t_q            <= '0;
              end else begin
                t_q <= t_q + 1'b1;
              end
            end
            PH_UP_F: begin
              if (!pass_q || t_q == C_FMAX) begin
                if (!pass_q && t_q == '0) begin
                  maxc_q[lane_q] <= maxc_q[lane_q] - 1'b1;
                  maxf_q[lane_q] <= F_MAX;
                end else if (!pass_q) begin
                  maxf_q[lane_q] <= FW'(t_q - 1'b1);
                end else begin
                  maxf_q[lane_q] <= F_MAX;
                end
                phase_q <= PH_LO_C;
                t_q     <= C_LOST;
              end else begin
                t_q <= t_q + 1'b1;
              end
            end
            PH_LO_C: begin
              if (!pass_q || t_q == bnd_c || t_q < bnd_c + 1'b1) begin
                minc_q[lane_q] <= (!pass_q || t_q == bnd_c) ? t_q : t_q - 1'b1;
                phase_q        <= PH_LO_F;
                t_q            <= C_FMAX;
              end else begin
                t_q <= t_q - 1'b1;
              end
            end
            default: begin
              if (!pass_q || t_q == bnd_f) begin
                if (!pass_q && t_q == C_FMAX) begin
                  minc_q[lane_q] <= minc_q[lane_q] + 1'b1;
                  minf_q[lane_q] <= '0;
                end else if (!pass_q) begin
                  minf_q[lane_q] <= FW'(t_q + 1'b1);
                end else begin
                  minf_q[lane_q] <= t_q[FW-1:0];
                end
                if (lane_q == LAST_LANE) begin
                  state_q <= ST_CENTRE;
                end else begin
                  lane_q  <= lane_q + 1'b1;
                  phase_q <= PH_UP_C;
                  t_q     <= C_UPST;
                end
              end else begin
                t_q <= t_q - 1'b1;
              end
            end
          endcase
        end
        ST_CENTRE: begin
          dly_word_o <= final_word;
          done_o     <= 1'b1;
          busy_o     <= 1'b0;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dqs_cal_checker.sv
module dqs_cal_checker #(
  parameter int          RW      = 16,
  parameter int          BW      = 2,
  parameter logic [RW-1:0] PW    = 16'h7474,
  parameter int          BIAS_UP = 3,
  parameter int          BIAS_LO = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          test_req_o,
  input logic [BW-1:0] test_bias_o,
  input logic          test_done_i,
  input logic [RW-1:0] dly_word_o
);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R1
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    test_req_o |=> !test_req_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !test_req_o);

  // R10
  bias_code_chk: assert property (@(posedge clk) disable iff (rst)
    test_req_o |-> (test_bias_o == BW'(BIAS_UP) || test_bias_o == BW'(BIAS_LO)));

  // R2
  park_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && test_done_i) |=> (dly_word_o == PW));

  // R12
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind dqs_cal_engine dqs_cal_checker #(
  .RW(RW), .BW(BW), .PW(PARK_WORD), .BIAS_UP(BIAS_UP), .BIAS_LO(BIAS_LO)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .test_req_o(test_req_o), .test_bias_o(test_bias_o), .test_done_i(test_done_i),
  .dly_word_o(dly_word_o)
);

// File: tb/tb_dqs_cal_engine.sv
`timescale 1ns/1ps
module tb_dqs_cal_engine;
  localparam int FW = 4;
  localparam int NL = 2;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [3:0] dll_coarse_i = '0, dll_fine_i = '0;
  logic test_req_o;
  logic [1:0] test_bias_o;
  logic test_done_i = 1'b0;
  logic test_pass_i = 1'b0;
  logic [15:0] dly_word_o;
  logic busy_o, done_o;
  logic [9:0] max_c_o, min_c_o;
  logic [7:0] max_f_o, min_f_o;

  always #10 clk = ~clk;

  dqs_cal_engine dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .dll_coarse_i(dll_coarse_i), .dll_fine_i(dll_fine_i),
    .test_req_o(test_req_o), .test_bias_o(test_bias_o),
    .test_done_i(test_done_i), .test_pass_i(test_pass_i),
    .dly_word_o(dly_word_o), .busy_o(busy_o), .done_o(done_o),
    .max_c_o(max_c_o), .max_f_o(max_f_o), .min_c_o(min_c_o), .min_f_o(min_f_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int lo_w [NL];
  int hi_w [NL];
  int lat = 1;

  // observed probes
  int obs_n = 0;
  int obs_word [256];
  int obs_bias [256];
  // expected
  int exp_n;
  int exp_word [256];
  int exp_bias [256];
  int e_maxc [NL], e_maxf [NL], e_minc [NL], e_minf [NL];
  int e_final;

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit passf(int w);
    bit ok = 1;
    for (int i = 0; i < NL; i++) begin
      int b = (w >> (8*i)) & 8'hFF;
      if (b < lo_w[i] || b > hi_w[i]) ok = 0;
    end
    return ok;
  endfunction

  function automatic int mk(int lane, int c, int f);
    int w = 0;
    for (int i = 0; i < NL; i++) begin
      int b = (i == lane) ? (((c > 15) ? 15 : c) * 16 + f) : 8'h74;
      w = w | (b << (8*i));
    end
    return w;
  endfunction

  task automatic push(int w, int b);
    exp_word[exp_n] = w;
    exp_bias[exp_n] = b;
    exp_n++;
  endtask

  task automatic model(int dc, int df);
    int bc, bf, t, mc, mf, nc, nf, w;
    exp_n = 0;
    e_final = 0;
    bc = (dc <= 8) ? 8 - dc : 0;
    bf = (df <= 8) ? 8 - df : 0;
    for (int L = 0; L < NL; L++) begin
      t = 7;
      forever begin
        w = mk(L, t, 15); push(w, 3);
        if (!passf(w)) break;
        t++;
        if (t > 15) break;
      end
      mc = t;
      t = 0;
      forever begin
        w = mk(L, mc, t); push(w, 3);
        if (!passf(w)) break;
        t++;
        if (t > 15) break;
      end
      t--;
      if (t < 0) begin mc--; mf = 15; end else mf = t;
      t = 6;
      forever begin
        w = mk(L, t, 0); push(w, 1);
        if (!passf(w) || t == bc) break;
        t--;
        if (t < bc) break;
      end
      nc = t;
      t = 15;
      forever begin
        w = mk(L, nc, t); push(w, 1);
        if (!passf(w)) begin t++; break; end
        if (t == bf) break;
        t--;
        if (t < bf) break;
      end
      if (t == 16) begin nc++; nf = 0; end else nf = t;
      e_maxc[L] = mc; e_maxf[L] = mf; e_minc[L] = nc; e_minf[L] = nf;
      begin
        int cs, tv, cc, cf;
        cs = mc + nc;
        cc = cs >> 1;
        tv = (cs % 2) * 4 + ((mf + nf) >> 1);
        if (tv >= 16) begin cc++; cf = tv - 16 + 8; end else cf = tv;
        e_final = e_final | ((((cc & 15) << 4) | cf) << (8*L));
      end
    end
  endtask

  // test stub
  int lat_cnt = 0;
  bit pend = 0;
  int cap = 0;
  always @(posedge clk) begin
    test_done_i <= 1'b0;
    if (rst) begin
      pend <= 0;
    end else if (test_req_o) begin
      pend    <= 1;
      lat_cnt <= lat;
      cap     <= int'(dly_word_o);
    end else if (pend) begin
      if (lat_cnt <= 1) begin
        test_done_i <= 1'b1;
        test_pass_i <= passf(cap);
        pend        <= 0;
      end else begin
        lat_cnt <= lat_cnt - 1;
      end
    end
  end

  // probe recorder and park monitor
  bit chk_next = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (chk_next)  // R2 park after each test done
        check(dly_word_o == 16'h7474, "R2 park", int'(dly_word_o), 16'h7474);
      chk_next = test_done_i;
      if (test_req_o && obs_n < 256) begin
        obs_word[obs_n] = int'(dly_word_o);
        obs_bias[obs_n] = int'(test_bias_o);
        obs_n++;
      end
    end
  end

  task automatic run_case(int l0, int h0, int l1, int h1, int dc, int df, bit disturb);
    int cyc = 0;
    int bad_w = -1, bad_b = -1;
    lo_w[0] = l0; hi_w[0] = h0; lo_w[1] = l1; hi_w[1] = h1;
    lat = 1 + int'($urandom_range(0, 2));
    model(dc, df);
    @(negedge clk);
    obs_n = 0;
    dll_coarse_i = 4'(dc); dll_fine_i = 4'(df);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1;
      dll_coarse_i = 4'($urandom_range(0, 15));
      dll_fine_i   = 4'($urandom_range(0, 15));
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check(done_o, "R11 done seen", int'(done_o), 1);
    check(!busy_o, "R11 idle at done", int'(busy_o), 0);
    // R9 centred word
    check(dly_word_o == 16'(e_final), "R9 final word", int'(dly_word_o), e_final);
    for (int L = 0; L < NL; L++) begin
      check(int'(max_c_o[L*5 +: 5]) == e_maxc[L], "R3 coarse max", int'(max_c_o[L*5 +: 5]), e_maxc[L]);
      check(int'(max_f_o[L*4 +: 4]) == e_maxf[L], "R4 fine max", int'(max_f_o[L*4 +: 4]), e_maxf[L]);
      check(int'(min_c_o[L*5 +: 5]) == e_minc[L], "R6 R5 coarse min", int'(min_c_o[L*5 +: 5]), e_minc[L]);
      check(int'(min_f_o[L*4 +: 4]) == e_minf[L], "R7 fine min", int'(min_f_o[L*4 +: 4]), e_minf[L]);
    end
    // R8 probe order and count
    check(obs_n == exp_n, "R8 probe count", obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      if (bad_w < 0 && obs_word[i] != exp_word[i]) bad_w = i;
      if (bad_b < 0 && obs_bias[i] != exp_bias[i]) bad_b = i;
    end
    check(bad_w < 0, "R8 R2 probe words", (bad_w < 0) ? 0 : obs_word[bad_w], (bad_w < 0) ? 0 : exp_word[bad_w]);
    check(bad_b < 0, "R10 bias codes", (bad_b < 0) ? 0 : obs_bias[bad_b], (bad_b < 0) ? 0 : exp_bias[bad_b]);
    if (disturb)  // R12 run unaffected by start while busy
      check(obs_n == exp_n && dly_word_o == 16'(e_final), "R12 restart ignored", obs_n, exp_n);
    @(negedge clk);
    check(!done_o, "R11 done one cycle", int'(done_o), 0);
    check(dly_word_o == 16'(e_final), "R11 word held", int'(dly_word_o), e_final);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dly_word_o == 0 && !busy_o && !done_o && !test_req_o, "R1 reset outputs",
          int'(dly_word_o), 0);
    check(max_c_o == 0 && min_c_o == 0 && max_f_o == 0 && min_f_o == 0, "R1 reset results",
          int'(max_c_o), 0);
    rst = 1'b0;
    @(negedge clk);
    // R4 borrow and R7 carry on lane 0
    run_case(8'h40, 8'h9F, 8'h20, 8'hC3, 8, 8, 0);
    // R3 saturation above 15 with R5 bounds at 8
    run_case(8'h00, 8'hFF, 8'h00, 8'hFF, 0, 0, 0);
    // R9 centre carry (t >= 16)
    run_case(8'h5A, 8'hAF, 8'h5A, 8'hAF, 8, 8, 0);
    // narrow window, R5 with reading above 8
    run_case(8'h74, 8'h74, 8'h74, 8'h74, 15, 12, 0);
    // R5 intermediate bound, R12 restart ignored
    run_case(8'h10, 8'hE0, 8'h33, 8'h9B, 5, 3, 1);
    for (int r = 0; r < 18; r++) begin
      run_case(int'($urandom_range(0, 8'h74)), int'($urandom_range(8'h74, 8'hFF)),
               int'($urandom_range(0, 8'h74)), int'($urandom_range(8'h74, 8'hFF)),
               int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), (r % 4) == 1);
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule